// File: doc/BRIEF.md
# Color-Mosaic Gain Steering Controller

This block chooses, once per pixel clock, which of four programmable gain words drives a pixel gain amplifier. The choice follows the color filter layout of the image sensor. The block has two layouts. The first is a 2x2 mosaic: even lines alternate between gain 0 and gain 1, and odd lines alternate between gain 2 and gain 3. The second is a three-color stripe, in which every line cycles through gains 0, 1 and 2.

Both sync inputs are active low and can arrive at any time relative to the pixel clock. A two-flop register stage captures each one, and an edge detector finds its falling edges. A falling frame sync restarts the whole pattern. A falling line sync starts a short delay, and when the delay ends the horizontal position counter restarts. The pixel steering is tied to that restart, so the first pixel of every line takes the first entry of that line's pattern. The block registers the selected gain word and presents it one clock after its index.

Top module: `mosaic_gain_steer`

## Requirements
- R1: While reset is asserted, and on the first clock after it is released, `gainIdx` is 0 and `gainWord` is 0. The line phase starts as even, which gives the 0,1 pattern.
- R2: On each clock, `gainWord` takes the value of the gain input that the previous `gainIdx` selected: index 0 selects `gain0`, index 1 selects `gain1`, index 2 selects `gain2` and index 3 selects `gain3`.
- R3: When `vdN` falls, the second rising clock edge after the fall sets `gainIdx` to 0. In mosaic mode it also sets the line phase to even.
- R4: In mosaic mode, between restarts, `gainIdx` alternates 0,1,0,1 on an even line and 2,3,2,3 on an odd line. Bit 1 of the index is the line phase.
- R5: When `hdN` falls, the horizontal restart happens on the sixth rising clock edge after the fall. In mosaic mode that edge inverts the line phase and sets `gainIdx` to the first entry of the new line pattern (0 or 2).
- R6: In stripe mode, `gainIdx` repeats 0,1,2 and never takes the value 3. A frame restart and a horizontal restart both set it to 0. A horizontal restart does not change the line phase.
- R7: A frame sync fall and a line sync fall that are sampled on the same clock edge count as a frame restart only, and no horizontal restart follows. A frame restart also cancels any horizontal restart that is still pending.
- R8: `modeStripe` selects the layout: 0 selects the mosaic, 1 selects the stripe. The block samples it on each clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Asynchronous active-low reset |
| vdN | input | 1 | Active-low frame sync, asynchronous to `clk` |
| hdN | input | 1 | Active-low line sync, asynchronous to `clk` |
| modeStripe | input | 1 | Layout select: 0 for mosaic, 1 for stripe |
| gain0 | input | GAIN_W | Gain word for index 0 |
| gain1 | input | GAIN_W | Gain word for index 1 |
| gain2 | input | GAIN_W | Gain word for index 2 |
| gain3 | input | GAIN_W | Gain word for index 3 |
| gainIdx | output | 2 | Registered steering index |
| gainWord | output | GAIN_W | Registered gain word, one clock behind `gainIdx` |

## Verification
The properties that relate the index before and after an edge require `modeStripe` to hold the same value on both cycles. A change of layout between restarts has no defined pattern. Every mode change in the stimulus therefore falls together with a frame sync pulse, and index comparisons are suspended until the frame restart has taken effect. The sync pulses last at least two clocks, so the synchronizer never misses one, and the gain words change only at a fixed point shortly after a clock edge.

// File: rtl/steer_pkg.sv
package steer_pkg;

  localparam int IDX_W = 2;

  typedef enum logic {
    MODE_MOSAIC = 1'b0,
    MODE_STRIPE = 1'b1
  } steer_mode_e;

  // Strobes from control to datapath; each valid for one clock.
  typedef struct packed {
    logic vdRestart;    // frame restart of the pattern
    logic lineRestart;  // delayed horizontal counter restart
  } steer_ctl_t;

endpackage

// File: rtl/steer_ctrl.sv
module steer_ctrl
  import steer_pkg::*;
#(
  parameter int HD_DELAY = 6  // rising edges from line sync fall to restart (>= 3)
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       vdN,
  input  logic       hdN,
  output steer_ctl_t ctl
);

  localparam int DLY_W = $clog2(HD_DELAY);
  localparam logic [DLY_W-1:0] DLY_LOAD = DLY_W'(HD_DELAY - 2);
  localparam logic [DLY_W-1:0] DLY_FIRE = DLY_W'(1);

  logic [1:0] vdSync;
  logic [1:0] hdSync;
  logic       vdFall;
  logic       hdFall;
  logic       hdStart;
  logic       dlyFire;
  logic [DLY_W-1:0] dlyCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vdSync <= 2'b11;
      hdSync <= 2'b11;
    end else begin
      vdSync <= {vdSync[0], vdN};
      hdSync <= {hdSync[0], hdN};
    end
  end

  assign vdFall  = vdSync[1] & ~vdSync[0];
  assign hdFall  = hdSync[1] & ~hdSync[0];
  assign hdStart = hdFall & ~vdFall;
  assign dlyFire = (dlyCnt == DLY_FIRE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dlyCnt <= '0;
    end else if (vdFall) begin
      dlyCnt <= '0;
    end else if (hdStart) begin
      dlyCnt <= DLY_LOAD;
    end else if (dlyCnt != '0) begin
      dlyCnt <= dlyCnt - DLY_FIRE;
    end
  end

  always_comb begin
    ctl.vdRestart   = vdFall;
    ctl.lineRestart = dlyFire & ~vdFall;
  end

endmodule

// File: rtl/steer_datapath.sv
module steer_datapath
  import steer_pkg::*;
#(
  parameter int GAIN_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              modeStripe,
  input  steer_ctl_t        ctl,
  input  logic [GAIN_W-1:0] gain0,
  input  logic [GAIN_W-1:0] gain1,
  input  logic [GAIN_W-1:0] gain2,
  input  logic [GAIN_W-1:0] gain3,
  output logic [IDX_W-1:0]  gainIdx,
  output logic [GAIN_W-1:0] gainWord
);

  localparam int NUM_GAIN = 1 << IDX_W;
  localparam logic [1:0] STRIPE_LAST = 2'd2;

  logic [GAIN_W-1:0] gainArr [NUM_GAIN];
  logic              lineOdd, lineOddNext;
  logic [1:0]        pixCnt, pixCntNext;
  logic [IDX_W-1:0]  idxNext;
  steer_mode_e       mode;

  assign gainArr[0] = gain0;
  assign gainArr[1] = gain1;
  assign gainArr[2] = gain2;
  assign gainArr[3] = gain3;
  assign mode = steer_mode_e'(modeStripe);

  always_comb begin
    lineOddNext = lineOdd;
    pixCntNext  = pixCnt;
    if (ctl.vdRestart) begin
      lineOddNext = 1'b0;
      pixCntNext  = 2'd0;
    end else if (ctl.lineRestart) begin
      pixCntNext = 2'd0;
      if (mode == MODE_MOSAIC) lineOddNext = ~lineOdd;
    end else if (mode == MODE_STRIPE) begin
      pixCntNext = (pixCnt >= STRIPE_LAST) ? 2'd0 : pixCnt + 2'd1;
    end else begin
      pixCntNext = {1'b0, ~pixCnt[0]};
    end
    idxNext = (mode == MODE_STRIPE) ? pixCntNext : {lineOddNext, pixCntNext[0]};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lineOdd  <= 1'b0;
      pixCnt   <= 2'd0;
      gainIdx  <= '0;
      gainWord <= '0;
    end else begin
      lineOdd  <= lineOddNext;
      pixCnt   <= pixCntNext;
      gainIdx  <= idxNext;
      gainWord <= gainArr[gainIdx];
    end
  end

endmodule

// File: rtl/mosaic_gain_steer.sv
module mosaic_gain_steer
  import steer_pkg::*;
#(
  parameter int GAIN_W   = 10,
  parameter int HD_DELAY = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              vdN,
  input  logic              hdN,
  input  logic              modeStripe,
  input  logic [GAIN_W-1:0] gain0,
  input  logic [GAIN_W-1:0] gain1,
  input  logic [GAIN_W-1:0] gain2,
  input  logic [GAIN_W-1:0] gain3,
  output logic [1:0]        gainIdx,
  output logic [GAIN_W-1:0] gainWord
);

  steer_ctl_t ctl;

  steer_ctrl #(.HD_DELAY(HD_DELAY)) i_ctrl (
    .clk  (clk),
    .rstN (rstN),
    .vdN  (vdN),
    .hdN  (hdN),
    .ctl  (ctl)
  );

  steer_datapath #(.GAIN_W(GAIN_W)) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .modeStripe (modeStripe),
    .ctl        (ctl),
    .gain0      (gain0),
    .gain1      (gain1),
    .gain2      (gain2),
    .gain3      (gain3),
    .gainIdx    (gainIdx),
    .gainWord   (gainWord)
  );

endmodule

// File: rtl/steer_checker.sv
module steer_checker
  import steer_pkg::*;
#(
  parameter int GAIN_W = 10
) (
  input logic              clk,
  input logic              rstN,
  input logic              modeStripe,
  input logic [GAIN_W-1:0] gain0,
  input logic [GAIN_W-1:0] gain1,
  input logic [GAIN_W-1:0] gain2,
  input logic [GAIN_W-1:0] gain3,
  input logic [1:0]        gainIdx,
  input logic [GAIN_W-1:0] gainWord,
  input steer_ctl_t        ctl
);

  logic pastRun;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pastRun <= 1'b0;
    else       pastRun <= 1'b1;
  end

  AST_WORD_FOLLOWS_IDX: assert property (@(posedge clk) disable iff (!rstN)
    pastRun |-> gainWord == ($past(gainIdx) == 2'd0 ? $past(gain0) :
                             $past(gainIdx) == 2'd1 ? $past(gain1) :
                             $past(gainIdx) == 2'd2 ? $past(gain2) : $past(gain3))); // R2

  AST_FRAME_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    ctl.vdRestart |=> gainIdx == 2'd0); // R3

  AST_MOSAIC_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (pastRun && !modeStripe && !$past(modeStripe) && !ctl.vdRestart && !ctl.lineRestart)
      |=> (gainIdx[1] == $past(gainIdx[1])) && (gainIdx[0] != $past(gainIdx[0]))); // R4

  AST_MOSAIC_LINE_FLIP: assert property (@(posedge clk) disable iff (!rstN)
    (pastRun && !modeStripe && !$past(modeStripe) && ctl.lineRestart)
      |=> gainIdx == {~$past(gainIdx[1]), 1'b0}); // R5

  AST_STRIPE_NO_THREE: assert property (@(posedge clk) disable iff (!rstN)
    (pastRun && $past(modeStripe)) |-> gainIdx != 2'd3); // R6

  AST_STRIPE_LINE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (modeStripe && ctl.lineRestart) |=> gainIdx == 2'd0); // R6

endmodule

bind mosaic_gain_steer steer_checker #(.GAIN_W(GAIN_W)) i_steer_checker (
  .clk        (clk),
  .rstN       (rstN),
  .modeStripe (modeStripe),
  .gain0      (gain0),
  .gain1      (gain1),
  .gain2      (gain2),
  .gain3      (gain3),
  .gainIdx    (gainIdx),
  .gainWord   (gainWord),
  .ctl        (ctl)
);

// File: tb/test_mosaic_gain_steer.sv
module test_mosaic_gain_steer;

  localparam int GAIN_W   = 10;
  localparam int HD_DELAY = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic vdN = 1'b1;
  logic hdN = 1'b1;
  logic modeStripe = 1'b0;
  logic [GAIN_W-1:0] gain0 = 10'h0A1, gain1 = 10'h152, gain2 = 10'h2C3, gain3 = 10'h3F4;
  logic [1:0]        gainIdx;
  logic [GAIN_W-1:0] gainWord;

  int checks = 0;
  int errors = 0;
  logic  cmpEn = 1'b0;
  string curReq = "R1";

  typedef struct {
    logic [1:0]        idx;
    logic [GAIN_W-1:0] word;
    logic              en;
    string             req;
  } exp_t;
  exp_t expQ[$];

  always #10 clk = ~clk;  // 50 MHz

  mosaic_gain_steer #(.GAIN_W(GAIN_W), .HD_DELAY(HD_DELAY)) i_mosaic_gain_steer (
    .clk(clk), .rstN(rstN), .vdN(vdN), .hdN(hdN), .modeStripe(modeStripe),
    .gain0(gain0), .gain1(gain1), .gain2(gain2), .gain3(gain3),
    .gainIdx(gainIdx), .gainWord(gainWord)
  );

  // Reference model built from the requirements, sampled on each rising edge
  logic mVdPrev = 1'b1, mHdPrev = 1'b1, mVdAct = 1'b0, mOdd = 1'b0;
  int   mHdAge = 0;
  int   mPos = 0;
  logic [1:0] mIdx = 2'd0;

  function automatic logic [GAIN_W-1:0] pickGain(input logic [1:0] i);
    case (i)
      2'd0: return gain0;
      2'd1: return gain1;
      2'd2: return gain2;
      default: return gain3;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mVdPrev = 1'b1; mHdPrev = 1'b1; mVdAct = 1'b0; mOdd = 1'b0;
      mHdAge = 0; mPos = 0; mIdx = 2'd0;
    end else begin
      exp_t e;
      logic vdSeen, hdSeen, hRestart;
      e.word  = pickGain(mIdx);
      vdSeen  = mVdPrev & ~vdN;
      hdSeen  = mHdPrev & ~hdN;
      hRestart = (mHdAge == HD_DELAY - 1);           // sixth edge after HD fall (R5)
      if (mVdAct) begin                               // second edge after VD fall (R3)
        mOdd = 1'b0; mPos = 0;
      end else if (hRestart) begin
        mPos = 0;
        if (!modeStripe) mOdd = ~mOdd;
      end else begin
        mPos = modeStripe ? (mPos + 1) % 3 : (mPos + 1) % 2;
      end
      if (hdSeen && !vdSeen)            mHdAge = 1;  // R7: same-edge HD ignored
      else if (mVdAct || hRestart)      mHdAge = 0;  // R7: VD cancels pending restart
      else if (mHdAge != 0)             mHdAge = mHdAge + 1;
      mVdAct  = vdSeen;
      mVdPrev = vdN;
      mHdPrev = hdN;
      mIdx  = modeStripe ? 2'(mPos) : {mOdd, 1'(mPos)};
      e.idx = mIdx;
      e.en  = cmpEn;
      e.req = curReq;
      expQ.push_back(e);
    end
  end

  // Monitor: compare away from the rising edge
  always @(negedge clk) begin
    if (expQ.size() != 0) begin
      exp_t e;
      e = expQ.pop_front();
      checks++;
      if (gainWord !== e.word) begin
        errors++;
        $display("FAIL R2 gainWord actual=%h expected=%h", gainWord, e.word);
      end
      if (e.en) begin
        checks++;
        if (gainIdx !== e.idx) begin
          errors++;
          $display("FAIL %s gainIdx actual=%0d expected=%0d", e.req, gainIdx, e.idx);
        end
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic frameSync(input int lowCycles);
    vdN = 1'b0; tick(lowCycles); vdN = 1'b1;
  endtask

  task automatic lineSync(input int lowCycles);
    hdN = 1'b0; tick(lowCycles); hdN = 1'b1;
  endtask

  task automatic setMode(input logic stripe);
    cmpEn = 1'b0;
    modeStripe = stripe;
    frameSync(2);
    tick(1);
    cmpEn = 1'b1;
  endtask

  initial begin
    #4_000_000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    tick(4);
    @(negedge clk);
    checks++;
    if (gainIdx !== 2'd0 || gainWord !== '0) begin
      errors++;
      $display("FAIL R1 reset idx/word actual=%0d/%h expected=0/000", gainIdx, gainWord);
    end
    @(posedge clk); #2;
    rstN = 1'b1;
    cmpEn = 1'b1;
    curReq = "R1"; tick(1);
    curReq = "R4"; tick(7);

    curReq = "R3"; frameSync(3); tick(4);
    for (int ln = 0; ln < 4; ln++) begin
      curReq = "R5"; lineSync(2); tick(6);
      curReq = "R4"; tick(5 + ln);
      gain0 = gain0 + 10'd37; gain2 = gain2 ^ 10'h155;
    end
    curReq = "R3"; frameSync(2); tick(5);

    curReq = "R7"; vdN = 1'b0; hdN = 1'b0; tick(2); vdN = 1'b1; hdN = 1'b1; tick(12);
    curReq = "R7"; lineSync(2); tick(1); frameSync(2); tick(10);
    curReq = "R5"; lineSync(3); tick(12);

    setMode(1'b1);
    curReq = "R8"; tick(7);
    for (int ln = 0; ln < 3; ln++) begin
      curReq = "R6"; lineSync(2); tick(8 + ln);
      gain1 = gain1 + 10'd91;
    end
    curReq = "R6"; frameSync(2); tick(8);
    curReq = "R7"; vdN = 1'b0; hdN = 1'b0; tick(3); vdN = 1'b1; hdN = 1'b1; tick(12);

    setMode(1'b0);
    curReq = "R8"; tick(5);
    curReq = "R5"; lineSync(2); tick(9);
    lineSync(2); tick(9);
    tick(2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule